// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block supervises software through a byte-wide register port. Once started, a 16-bit up-counter advances on a tick. The tick comes from the system clock through a programmable 12-bit divider, with one tick every ratio+1 clocks. Software must refresh the counter inside a window. A refresh that comes too early is a fault. If no refresh arrives before the count reaches the maximum threshold, that is also a fault. Either fault produces a one-cycle reset request and stops the supervisor.

A separate 16-bit warning down-counter runs at half the tick rate. When it runs out, it raises a warning interrupt, which gives software a last chance to refresh. While the supervisor runs, its divider and its thresholds cannot be changed. It can only be stopped by a two-write key on the control register.

Top module: `wdt_window`

## Requirements
- R1: Register offsets are as follows. 0 is control: bit 0 starts the supervisor, bits 7:4 are the upper four bits of the divider ratio, and a read returns {ratio[11:8], 000, running}. 1 holds divider ratio bits 7:0. 2 and 3 hold the minimum threshold, low byte then high byte. 4 and 5 hold the warning threshold, low byte then high byte. 6 and 7 hold the maximum threshold, low byte then high byte. A write to 8 is a refresh. 9 is status: bit 0 running, bit 1 warning counter non-zero while running, bit 2 early-refresh flag, bit 3 warning flag, bit 4 maximum-expiry flag. After reset every readback is 0 and both outputs are low.
- R2: After a start or a valid refresh, with threshold M and ratio R (ratio = {ctrl[7:4], reg1}), rst_req goes high exactly M*(R+1) clocks later. It stays high for one cycle only. The supervisor then stops and status reads 0x10.
- R3: A maximum threshold of 0 expires only after the counter wraps, which takes 65536 ticks.
- R4: The warning counter loads the warning threshold W on start and on refresh. It decrements every second tick. warn_irq rises 2*W*(R+1) clocks after the load, stays high until a refresh or a stop, and sets status bit 3. Status bit 1 is high while the counter is non-zero. W = 0 never raises a warning.
- R5: A refresh while the count is below the minimum threshold raises rst_req in the next cycle, stops the supervisor and sets status bit 2. A refresh at or above the minimum restarts both counters and the divider, and clears warn_irq.
- R6: While running, writes to offsets 0 to 7 leave every readback unchanged, except for the stop key on offset 0.
- R7: While running, a control write of 0x01 followed by a control write of 0x02 as the very next bus write stops the supervisor. Any other write in between, or a second value other than 0x02, cancels the key. A second 0x01 re-arms it. warn_irq falls one cycle after a stop.
- R8: A refresh while stopped has no effect.
- R9: Starting the supervisor clears all status flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Combinational read data |
| warn_irq | output | 1 | Warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach is a refresh on the exact cycle at which the count equals the minimum threshold, together with its neighbour one count lower. The bench uses a divider ratio of 0, so the count advances once per clock. It then issues the refresh a computed number of clocks after the start write, which puts the count at exactly min-1 or min. The key sequence is exercised with interleaved refreshes, wrong second values and repeated arming. The wrap case runs the full 65536 ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 12;
  localparam int ADDR_W = 4;
  localparam int N_THR  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIVLO = 4'd1;
  localparam logic [ADDR_W-1:0] A_THR0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_KICK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd9;

  localparam logic [BYTE_W-1:0] KEY_ARM  = 8'h01;
  localparam logic [BYTE_W-1:0] KEY_FIRE = 8'h02;

  function automatic logic [DIV_W-1:0] join_ratio(input logic [DIV_W-BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         fault,
  input  logic                         early_evt,
  input  logic                         warn_evt,
  input  logic                         max_evt,
  input  logic                         warn_busy,
  output logic                         run,
  output logic                         start_pulse,
  output logic                         kick_pulse,
  output logic [DIV_W-1:0]             ratio,
  output logic [CNT_W-1:0]             min_thr,
  output logic [CNT_W-1:0]             wrn_thr,
  output logic [CNT_W-1:0]             max_thr,
  output logic [BYTE_W-1:0]            rd_data
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic                          run_q;
  logic                          armed_q;
  logic [HI_W-1:0]               div_hi_q;
  logic [BYTE_W-1:0]             div_lo_q;
  logic [2:0]                    flag_q;
  logic [N_THR-1:0][CNT_W-1:0]   thr_all;

  logic ctrl_wr;
  logic key_fire;
  assign ctrl_wr     = wr_en && (wr_addr == A_CTRL);
  assign start_pulse = ctrl_wr && !run_q && wr_data[0];
  assign kick_pulse  = wr_en && (wr_addr == A_KICK) && run_q;
  assign key_fire    = ctrl_wr && run_q && armed_q && (wr_data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      div_hi_q <= '0;
      div_lo_q <= '0;
      flag_q   <= '0;
    end else begin
      if (fault || key_fire)  run_q <= 1'b0;
      else if (start_pulse)   run_q <= 1'b1;

      if (!run_q)             armed_q <= 1'b0;
      else if (wr_en)         armed_q <= ctrl_wr && (wr_data == KEY_ARM);

      if (ctrl_wr && !run_q)  div_hi_q <= wr_data[BYTE_W-1 -: HI_W];
      if (wr_en && (wr_addr == A_DIVLO) && !run_q) div_lo_q <= wr_data;

      if (start_pulse) flag_q <= '0;
      else             flag_q <= flag_q | {max_evt, warn_evt, early_evt};
    end
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_THR0 + 2*g);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_THR0 + 2*g + 1);
    logic [CNT_W-1:0] thr_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_r <= '0;
      end else if (wr_en && !run_q) begin
        if (wr_addr == LO_A) thr_r[BYTE_W-1:0]     <= wr_data;
        if (wr_addr == HI_A) thr_r[CNT_W-1:BYTE_W] <= wr_data;
      end
    end
    assign thr_all[g] = thr_r;
  end

  assign run     = run_q;
  assign ratio   = join_ratio(div_hi_q, div_lo_q);
  assign min_thr = thr_all[0];
  assign wrn_thr = thr_all[1];
  assign max_thr = thr_all[2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = {div_hi_q, 3'b000, run_q};
      A_DIVLO: rd_data = div_lo_q;
      4'd2:    rd_data = thr_all[0][BYTE_W-1:0];
      4'd3:    rd_data = thr_all[0][CNT_W-1:BYTE_W];
      4'd4:    rd_data = thr_all[1][BYTE_W-1:0];
      4'd5:    rd_data = thr_all[1][CNT_W-1:BYTE_W];
      4'd6:    rd_data = thr_all[2][BYTE_W-1:0];
      4'd7:    rd_data = thr_all[2][CNT_W-1:BYTE_W];
      A_STAT:  rd_data = {3'b000, flag_q, warn_busy, run_q};
      default: rd_data = '0;
    endcase
  end

  // R6: configuration cannot move in the cycle after one where the block runs
  assert_cfg_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(thr_all) && $stable(div_lo_q) && $stable(div_hi_q)));

  // R7: a stop that is not caused by a fault needs the key to have been armed
  assert_key_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_q) && !$past(fault)) |-> $past(armed_q));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick,
  output logic             half_tick
);
  logic [DIV_W-1:0] div_q;
  logic             phase_q;

  assign tick      = run && (div_q == ratio);
  assign half_tick = tick && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run || restart) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + DIV_W'(1);
    end
  end

  // R2: with a ratio above zero, two ticks are never adjacent
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && (ratio != '0)) |=> !tick);
endmodule

// File: rtl/wdt_counters.sv
module wdt_counters
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             kick,
  input  logic             tick,
  input  logic             half_tick,
  input  logic [CNT_W-1:0] min_thr,
  input  logic [CNT_W-1:0] wrn_thr,
  input  logic [CNT_W-1:0] max_thr,
  output logic             early_evt,
  output logic             warn_evt,
  output logic             max_evt,
  output logic             warn_busy,
  output logic             warn_irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wcnt_q;
  logic             warn_q;
  logic             rst_q;
  logic             reload;

  assign early_evt = kick && (cnt_q < min_thr);
  assign reload    = start || (kick && !early_evt);
  assign max_evt   = run && tick && !kick && (step_up(cnt_q) == max_thr);
  assign warn_evt  = run && half_tick && !kick && (wcnt_q == CNT_W'(1));
  assign warn_busy = run && (wcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
      warn_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (reload) begin
        cnt_q  <= '0;
        wcnt_q <= wrn_thr;
      end else if (run && tick) begin
        cnt_q <= step_up(cnt_q);
        if (half_tick && (wcnt_q != '0)) wcnt_q <= step_down(wcnt_q);
      end

      if (reload || !run) warn_q <= 1'b0;
      else if (warn_evt)  warn_q <= 1'b1;

      rst_q <= early_evt || max_evt;
    end
  end

  assign warn_irq = warn_q;
  assign rst_req  = rst_q;

  // R2: the reset request is a single-cycle pulse
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5: a reset request only follows a refresh or a tick
  assert_req_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(kick) || $past(tick)));

  // R4: the warning only rises once the down-counter is empty
  assert_warn_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_irq) |-> !warn_busy);

  // R7: the warning is withdrawn one cycle after the supervisor stops
  assert_warn_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> !warn_irq);
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              warn_irq,
  output logic              rst_req
);
  logic             run, start_pulse, kick_pulse;
  logic             tick, half_tick;
  logic             early_evt, warn_evt, max_evt, warn_busy, fault;
  logic [DIV_W-1:0] ratio;
  logic [CNT_W-1:0] min_thr, wrn_thr, max_thr;

  assign fault = early_evt || max_evt;

  wdt_regfile i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .fault(fault), .early_evt(early_evt), .warn_evt(warn_evt),
    .max_evt(max_evt), .warn_busy(warn_busy), .run(run), .start_pulse(start_pulse),
    .kick_pulse(kick_pulse), .ratio(ratio), .min_thr(min_thr), .wrn_thr(wrn_thr),
    .max_thr(max_thr), .rd_data(rd_data)
  );

  wdt_prescale i_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(start_pulse || kick_pulse),
    .ratio(ratio), .tick(tick), .half_tick(half_tick)
  );

  wdt_counters i_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start_pulse), .kick(kick_pulse),
    .tick(tick), .half_tick(half_tick), .min_thr(min_thr), .wrn_thr(wrn_thr),
    .max_thr(max_thr), .early_evt(early_evt), .warn_evt(warn_evt), .max_evt(max_evt),
    .warn_busy(warn_busy), .warn_irq(warn_irq), .rst_req(rst_req)
  );
endmodule

// File: tb/test_wdt_window.sv
`timescale 1ns/1ps
module test_wdt_window;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam logic [3:0] O_CTRL = 4'd0, O_DIV = 4'd1, O_MINL = 4'd2, O_MINH = 4'd3,
                         O_WRNL = 4'd4, O_WRNH = 4'd5, O_MAXL = 4'd6, O_MAXH = 4'd7,
                         O_KICK = 4'd8, O_STAT = 4'd9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       warn_irq, rst_req;
  int checks = 0;
  int errors = 0;

  wdt_window i_wdt_window (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .warn_irq(warn_irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic cfg(input int ratio, input int mn, input int wn, input int mx);
    wr(O_DIV, 8'(ratio)); wr(O_MINL, 8'(mn)); wr(O_MINH, 8'(mn >> 8));
    wr(O_WRNL, 8'(wn)); wr(O_WRNH, 8'(wn >> 8));
    wr(O_MAXL, 8'(mx)); wr(O_MAXH, 8'(mx >> 8));
  endtask

  task automatic go(input int ratio);
    wr(O_CTRL, {4'(ratio >> 8), 4'b0001});
  endtask

  task automatic run_until(input int lim, output int n_rst, output int n_warn);
    n_rst = -1; n_warn = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (warn_irq && n_warn < 0) n_warn = i;
      if (rst_req) begin n_rst = i; break; end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, nr, nw;
    do_reset();
    // R1: reset readback and outputs
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v); chk("R1", v, 0);
    end
    chk("R1", int'(rst_req), 0);
    chk("R1", int'(warn_irq), 0);

    // R2: expiry timing sweep over ratio and maximum threshold
    for (int r = 0; r < 4; r++) begin
      for (int m = 1; m < 5; m++) begin
        do_reset(); cfg(r, 0, 0, m); go(r);
        run_until(m * (r + 1) + 5, nr, nw);
        chk("R2", nr, m * (r + 1));
        @(negedge clk); chk("R2", int'(rst_req), 0);
        rd(O_STAT, v); chk("R2", v, 8'h10);
      end
    end
    // R2: upper ratio bits come from control bits 7:4
    do_reset(); cfg(12'h105, 0, 0, 2); go(12'h105);
    run_until(600, nr, nw); chk("R2", nr, 2 * (12'h105 + 1));

    // R3: maximum of zero wraps the full count
    do_reset(); cfg(0, 0, 0, 0); go(0);
    run_until(70000, nr, nw); chk("R3", nr, 65536);
    // R9: restart clears flags
    rd(O_STAT, v); chk("R9", v, 8'h10);
    go(0); rd(O_STAT, v); chk("R9", v, 8'h01);

    // R4: warning timing sweep
    for (int r = 0; r < 3; r++) begin
      for (int w = 1; w < 4; w++) begin
        do_reset(); cfg(r, 0, w, 200); go(r);
        rd(O_STAT, v); chk("R4", v & 2, 2);
        run_until(2 * w * (r + 1) + 3, nr, nw);
        if (nw < 0) nw = 0;
        chk("R4", nw, 2 * w * (r + 1));
        rd(O_STAT, v); chk("R4", v & 8'h0A, 8'h08);
        repeat (3) @(negedge clk); chk("R4", int'(warn_irq), 1);
      end
    end
    // R4: zero warning threshold never warns
    do_reset(); cfg(0, 0, 0, 20); go(0);
    run_until(30, nr, nw); chk("R4", nw, -1); chk("R4", nr, 20);

    // R5: refresh one count below the minimum
    do_reset(); cfg(0, 5, 0, 50); go(0);
    repeat (4) @(negedge clk);
    wr(O_KICK, 8'h00);
    chk("R5", int'(rst_req), 1);
    rd(O_STAT, v); chk("R5", v, 8'h04);
    // R5: refresh exactly at the minimum restarts both counters
    do_reset(); cfg(0, 5, 1, 50); go(0);
    repeat (5) @(negedge clk);
    chk("R5", int'(warn_irq), 1);
    wr(O_KICK, 8'h00);
    chk("R5", int'(rst_req), 0);
    chk("R5", int'(warn_irq), 0);
    run_until(60, nr, nw);
    chk("R5", nw, 2); chk("R5", nr, 50);

    // R6: configuration locked while running
    do_reset(); cfg(3, 0, 0, 1000); go(3);
    wr(O_MAXL, 8'h55); wr(O_MINL, 8'h11); wr(O_DIV, 8'h77); wr(O_CTRL, 8'hA0);
    rd(O_MAXL, v); chk("R6", v, 8'hE8);
    rd(O_MINL, v); chk("R6", v, 0);
    rd(O_DIV, v);  chk("R6", v, 3);
    rd(O_CTRL, v); chk("R6", v, 8'h01);

    // R7: key sequences
    do_reset(); cfg(8'hFF, 0, 0, 16'hFFFF); go(12'hFFF);
    wr(O_CTRL, 8'h01); wr(O_CTRL, 8'h02);
    rd(O_STAT, v); chk("R7", v, 0);
    go(12'hFFF);
    wr(O_CTRL, 8'h01); wr(O_KICK, 8'h00); wr(O_CTRL, 8'h02);
    rd(O_STAT, v); chk("R7", v & 1, 1);
    wr(O_CTRL, 8'h01); wr(O_CTRL, 8'h03); wr(O_CTRL, 8'h02);
    rd(O_STAT, v); chk("R7", v & 1, 1);
    wr(O_CTRL, 8'h02);
    rd(O_STAT, v); chk("R7", v & 1, 1);
    wr(O_CTRL, 8'h01); wr(O_CTRL, 8'h01); wr(O_CTRL, 8'h02);
    rd(O_STAT, v); chk("R7", v & 1, 0);
    chk("R7", int'(rst_req), 0);
    // R7: stop withdraws the warning
    do_reset(); cfg(0, 0, 1, 1000); go(0);
    repeat (3) @(negedge clk);
    chk("R7", int'(warn_irq), 1);
    wr(O_CTRL, 8'h01); wr(O_CTRL, 8'h02);
    @(negedge clk);
    chk("R7", int'(warn_irq), 0);

    // R8: refresh while stopped has no effect
    do_reset();
    wr(O_KICK, 8'h00);
    chk("R8", int'(rst_req), 0);
    rd(O_STAT, v); chk("R8", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule